// File: doc/BRIEF.md
# Serial Mouse Packet Encoder with Receive Queue

This block turns one pointing-device event (signed horizontal and vertical motion plus three button states) into a five-byte serial mouse packet. It writes the packet bytes into a small circular receive queue. A host data port reads the queue one byte per read strobe. A receive-available flag is high whenever at least one byte is waiting.

The encoder is a state machine with six named states:

- `ENC_IDLE`: waiting for an event.
- `ENC_HDR`: pushes the start byte.
- `ENC_DX`: pushes the horizontal byte.
- `ENC_DY`: pushes the vertical byte.
- `ENC_PAD0` and `ENC_PAD1`: push the two padding bytes.

An event is taken only in `ENC_IDLE` (transition IDLE→HDR). The machine then advances HDR→DX→DY→PAD0→PAD1→IDLE, one push per cycle. The queue never pushes back. A byte that arrives while the queue is full is discarded without notice.

The start byte begins at 0x87, and each pressed button clears one low bit. Motion values are clamped to the symmetric range -127..+127 and sent as 8-bit two's complement. The vertical value is negated before it is clamped.

Top module: `mouse_pkt_queue`

## Requirements
- R1: The first packet byte is 0x87 with bit 2 cleared when `evt_btn[2]` (left) is set, bit 1 cleared when `evt_btn[1]` (middle) is set, and bit 0 cleared when `evt_btn[0]` (right) is set.
- R2: The second byte is `evt_dx` clamped to -127..+127, as 8-bit two's complement.
- R3: The third byte is the negation of `evt_dy` clamped to -127..+127, as 8-bit two's complement.
- R4: The fourth and fifth bytes are 0x00.
- R5: An event taken on a clock edge makes `busy` high for the next five cycles. The five bytes are pushed in order, one per cycle, and `busy` is low in the sixth cycle.
- R6: `evt_valid` has no effect while `busy` is high. The queue receives only the bytes of the event that was taken.
- R7: A push into a queue holding DEPTH bytes is discarded. Bytes already queued are unchanged and the count never exceeds DEPTH.
- R8: A read strobe on a non-empty queue removes the oldest byte. That byte appears on `rd_data` in the cycle after the strobe. Without a strobe, `rd_data` holds its value.
- R9: A read strobe on an empty queue places 0x00 on `rd_data` and leaves the queue empty.
- R10: `rx_avail` is high exactly while the queue holds at least one byte, and stays high after a read that leaves bytes behind.
- R11: After reset, `busy`, `rx_avail` and `rd_data` are all zero.
- R12: When a push and a read happen in the same cycle, the full test uses the count from before the read. A push into a full queue is dropped even though a read frees a slot in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe, taken only when idle |
| evt_dx | input | DELTA_W | Signed horizontal motion |
| evt_dy | input | DELTA_W | Signed vertical motion |
| evt_btn | input | 3 | Buttons: [2] left, [1] middle, [0] right |
| busy | output | 1 | Encoder is pushing a packet |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| rx_avail | output | 1 | Queue not empty |

## Verification
The bench builds the block with DEPTH=8 and DELTA_W=9. With these values every 9-bit motion value, -256..+255, can be swept on both axes, together with all eight button patterns. This covers both clamp edges, and the -256 corner whose negation does not fit in the input width.

A depth of 8 is smaller than two packets. Two back-to-back events therefore overflow the queue after three bytes of the second packet. A read issued during the start-byte push of a third packet reaches the push-versus-read ordering on a full queue.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;

    typedef enum logic [2:0] {
        ENC_IDLE = 3'd0,
        ENC_HDR  = 3'd1,
        ENC_DX   = 3'd2,
        ENC_DY   = 3'd3,
        ENC_PAD0 = 3'd4,
        ENC_PAD1 = 3'd5
    } enc_state_t;

    localparam logic [7:0] HDR_BASE = 8'h87;
    localparam int         SAT_MAX  = 127;

    // clamp a wide signed value into -127..+127 and return its low byte
    function automatic logic [7:0] clamp_byte(input logic signed [31:0] v);
        logic signed [31:0] c;
        if (v > SAT_MAX)
            c = SAT_MAX;
        else if (v < -SAT_MAX)
            c = -SAT_MAX;
        else
            c = v;
        return c[7:0];
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [2:0] btn);
        return HDR_BASE & ~{5'b00000, btn};
    endfunction

endpackage

// File: rtl/mpq_encoder.sv
module mpq_encoder
    import mouse_pkt_pkg::*;
#(
    parameter int DELTA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [DELTA_W-1:0] evt_dx,
    input  logic [DELTA_W-1:0] evt_dy,
    input  logic [2:0]         evt_btn,
    output logic               busy,
    output logic               push_valid,
    output logic [7:0]         push_byte,
    output enc_state_t         state_o
);

    enc_state_t state_q, state_d;
    logic [7:0] hdr_q, dx_q, dy_q;
    logic signed [31:0] dx_ext, dy_ext;

    assign dx_ext = 32'($signed(evt_dx));
    assign dy_ext = 32'($signed(evt_dy));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_IDLE: if (evt_valid) state_d = ENC_HDR;
            ENC_HDR:  state_d = ENC_DX;
            ENC_DX:   state_d = ENC_DY;
            ENC_DY:   state_d = ENC_PAD0;
            ENC_PAD0: state_d = ENC_PAD1;
            ENC_PAD1: state_d = ENC_IDLE;
            default:  state_d = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            dx_q  <= '0;
            dy_q  <= '0;
        end else if (state_q == ENC_IDLE && evt_valid) begin
            hdr_q <= hdr_byte(evt_btn);
            dx_q  <= clamp_byte(dx_ext);
            dy_q  <= clamp_byte(-dy_ext);
        end
    end

    always_comb begin
        push_valid = 1'b1;
        push_byte  = 8'h00;
        unique case (state_q)
            ENC_IDLE: push_valid = 1'b0;
            ENC_HDR:  push_byte  = hdr_q;
            ENC_DX:   push_byte  = dx_q;
            ENC_DY:   push_byte  = dy_q;
            ENC_PAD0: push_byte  = 8'h00;
            ENC_PAD1: push_byte  = 8'h00;
            default:  push_valid = 1'b0;
        endcase
    end

    assign busy    = (state_q != ENC_IDLE);
    assign state_o = state_q;

endmodule

// File: rtl/mpq_fifo.sv
module mpq_fifo #(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [7:0]    push_byte,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count,
    output logic          rx_avail
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    // full test uses the count before any same-cycle read
    assign do_push = push_valid && (count != FULL_CNT);
    assign do_pop  = rd_en && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            rd_data <= 8'h00;
        end else begin
            if (do_push)
                wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
            if (rd_en)
                rd_data <= do_pop ? mem[rptr] : 8'h00;
        end
    end

    assign rx_avail = (count != '0);

endmodule

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue
    import mouse_pkt_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DELTA_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [DELTA_W-1:0] evt_dx,
    input  logic [DELTA_W-1:0] evt_dy,
    input  logic [2:0]         evt_btn,
    output logic               busy,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    output logic               rx_avail
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          push_valid;
    logic [7:0]    push_byte;
    logic [CW-1:0] fifo_count;
    enc_state_t    enc_state;

    mpq_encoder #(.DELTA_W(DELTA_W)) enc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_dx     (evt_dx),
        .evt_dy     (evt_dy),
        .evt_btn    (evt_btn),
        .busy       (busy),
        .push_valid (push_valid),
        .push_byte  (push_byte),
        .state_o    (enc_state)
    );

    mpq_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_byte  (push_byte),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .count      (fifo_count),
        .rx_avail   (rx_avail)
    );

endmodule

// File: rtl/mouse_pkt_queue_chk.sv
module mouse_pkt_queue_chk
    import mouse_pkt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt_valid,
    input logic          busy,
    input logic          push_valid,
    input logic [7:0]    push_byte,
    input enc_state_t    state,
    input logic [CW-1:0] count,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          rx_avail
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    assert_hdr_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && state == ENC_HDR) |-> (push_byte[7:3] == 5'b10000));

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && (state == ENC_PAD0 || state == ENC_PAD1)) |-> (push_byte == 8'h00));

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !busy) |=> (busy && state == ENC_HDR));

    assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && state == ENC_PAD1) |=> !busy);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && count == FULL_CNT && !rd_en) |=> $stable(count));

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == '0 && !push_valid) |=> (rd_data == 8'h00 && !rx_avail));

    assert_last_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count == CW'(1) && !push_valid) |=> !rx_avail);

    assert_full_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && rd_en && count == FULL_CNT) |=> (count == FULL_CNT - 1'b1));

endmodule

bind mouse_pkt_queue mouse_pkt_queue_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .busy       (busy),
    .push_valid (push_valid),
    .push_byte  (push_byte),
    .state      (enc_state),
    .count      (fifo_count),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rx_avail   (rx_avail)
);

// File: tb/mouse_pkt_queue_tb.sv
module mouse_pkt_queue_tb_top;

    localparam int PERIOD  = 10;
    localparam int DEPTH   = 8;
    localparam int DELTA_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0;
    logic [DELTA_W-1:0] evt_dx = '0;
    logic [DELTA_W-1:0] evt_dy = '0;
    logic [2:0] evt_btn = '0;
    logic rd_en = 1'b0;
    logic busy, rx_avail;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    mouse_pkt_queue #(.DEPTH(DEPTH), .DELTA_W(DELTA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
        .evt_dy(evt_dy), .evt_btn(evt_btn), .busy(busy), .rd_en(rd_en),
        .rd_data(rd_data), .rx_avail(rx_avail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > 127) return 127;
        if (v < -127) return -127;
        return v;
    endfunction

    function automatic logic [7:0] exp_byte(input int k, input int dx, input int dy, input logic [2:0] b);
        int t;
        case (k)
            0: return 8'h87 & ~{5'b0, b};
            1: begin t = clampv(dx); return t[7:0]; end
            2: begin t = clampv(-dy); return t[7:0]; end
            default: return 8'h00;
        endcase
    endfunction

    // returns at the sample point following the accepting edge
    task automatic send(input int dx, input int dy, input logic [2:0] b);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_dx = DELTA_W'(dx);
        evt_dy = DELTA_W'(dy);
        evt_btn = b;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_pkt(input int dx, input int dy, input logic [2:0] b, input int n, input int first);
        logic [7:0] v;
        for (int k = first; k < first + n; k++) begin
            rd(v);
            if (k == 0) chk(v == exp_byte(k, dx, dy, b), "R1", v, exp_byte(k, dx, dy, b));
            else if (k == 1) chk(v == exp_byte(k, dx, dy, b), "R2", v, exp_byte(k, dx, dy, b));
            else if (k == 2) chk(v == exp_byte(k, dx, dy, b), "R3", v, exp_byte(k, dx, dy, b));
            else chk(v == exp_byte(k, dx, dy, b), "R4", v, exp_byte(k, dx, dy, b));
            if (k < first + n - 1) chk(rx_avail == 1'b1, "R10", rx_avail, 1);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", busy, 0);
        chk(rx_avail == 1'b0, "R11", rx_avail, 0);
        chk(rd_data == 8'h00, "R11", rd_data, 0);

        // R1 R2 R3 R4 R5 R8 R10 sweep of every 9-bit motion value
        for (int i = 0; i < 512; i++) begin
            int dx, dy;
            logic [2:0] b;
            dx = i - 256;
            dy = ((i * 37 + 11) % 512) - 256;
            b = 3'(i);
            send(dx, dy, b);
            chk(busy == 1'b1, "R5", busy, 1);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk(busy == 1'b1, "R5", busy, 1);
            end
            @(negedge clk);
            chk(busy == 1'b0, "R5", busy, 0);
            chk(rx_avail == 1'b1, "R10", rx_avail, 1);
            read_pkt(dx, dy, b, 5, 0);
            chk(rx_avail == 1'b0, "R10", rx_avail, 0);
        end
        // extra corner: dy = -256 negates past the input width
        send(0, -256, 3'b000);
        repeat (5) @(negedge clk);
        read_pkt(0, -256, 3'b000, 5, 0);

        // R6 event during busy is ignored
        send(40, -3, 3'b101);
        evt_valid = 1'b1; evt_dx = DELTA_W'(-9); evt_dy = DELTA_W'(9); evt_btn = 3'b010;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R6", busy, 0);
        read_pkt(40, -3, 3'b101, 5, 0);
        chk(rx_avail == 1'b0, "R6", rx_avail, 0);

        // R7 overflow: two packets into depth 8 keep 8 bytes
        send(100, 20, 3'b001);
        repeat (5) @(negedge clk);
        send(-50, -60, 3'b110);
        repeat (5) @(negedge clk);
        // R12 read during header push of a third packet on a full queue
        send(5, 7, 3'b011);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
        chk(v == exp_byte(0, 100, 20, 3'b001), "R12", v, exp_byte(0, 100, 20, 3'b001));
        repeat (4) @(negedge clk);
        read_pkt(100, 20, 3'b001, 4, 1);
        read_pkt(-50, -60, 3'b110, 3, 0);
        rd(v);
        chk(v == exp_byte(1, 5, 7, 3'b011), "R12", v, exp_byte(1, 5, 7, 3'b011));
        chk(rx_avail == 1'b0, "R7", rx_avail, 0);

        // R9 empty read returns zero after a nonzero byte
        rd(v);
        chk(v == 8'h00, "R9", v, 0);
        chk(rx_avail == 1'b0, "R9", rx_avail, 0);
        // R8 rd_data holds without a strobe
        send(-20, 0, 3'b000);
        repeat (5) @(negedge clk);
        rd(v);
        @(negedge clk);
        chk(rd_data == 8'h87, "R8", rd_data, 8'h87);
        read_pkt(-20, 0, 3'b000, 4, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule